// File: doc/BRIEF.md
# Dual-Channel Storage Address Decoder

This block sits between a programmed-I/O request stream and the register targets of a two-channel storage controller. Every request carries an address, a byte size, a direction and write data. The decoder checks the address against five programmable windows: command and control blocks for each channel, plus one shared bus-master block. It subtracts the window base to form an offset and raises exactly one target strobe. It also records, per channel, whether the master or the slave drive is selected. Each decision is registered into one dispatch record that downstream logic consumes.

The dispatch record has a status. ROUTE means one target strobe is raised. SKIP means the access completes with no effect. EMPTY means no drive is selected on a one-byte command or control access, so a read returns zero and a write is dropped. ERR means the access is illegal. Both sides use valid/ready. A request is accepted when `acc_valid` and `acc_ready` are both high. `acc_ready` is high when the dispatch register is empty or is being drained in the same cycle. While `d_valid` is high and `d_ready` is low, every dispatch field holds its value and no new request is taken.

Top module: `stor_addr_decoder`

## Requirements
- R1: A request whose size is not 1, 2 or 4 produces status ERR (code 3) with no strobe, whatever the enables and address.
- R2: With `io_en` low, a legal-size request produces status SKIP (code 1), raises no strobe and leaves both device selects unchanged.
- R3: A window hits when base <= address < base + size. Windows are tried in the order primary command (strobe bit 0), primary control (bit 1), secondary command (bit 2), secondary control (bit 3), bus-master (bits 4/5), and the first hit wins. The reported offset is the address minus that window's base.
- R4: The primary command offset is shifted right by `IO_SHIFT` (default 1). The primary control offset has `CTRL_ADJ` (default 2) added. Secondary offsets are not adjusted.
- R5: In the bus-master window, offsets below `BM_CHAN_BYTES` (8) raise strobe bit 4 with that offset. Higher offsets raise bit 5 with the offset minus 8.
- R6: With `bm_en` low, writes into the bus-master window give SKIP. Reads there are still routed.
- R7: A command-window write whose adjusted offset is 6 loads that channel's select from data bit 4 (1 = slave, 0 = master) before the presence check. The access reports the updated select on `d_dev`. After reset both channels select the master.
- R8: On a command or control access whose selected drive is absent (`dev_present` bit {channel, select}, where bit 0 is the primary master and bit 3 is the secondary slave), size 1 gives EMPTY (code 2) and any other size gives ERR.
- R9: A legal-size request with `io_en` high that hits no window gives ERR.
- R10: A base write (`base_idx` 0..4 in the R3 window order) loads a nonzero value and ignores zero. Requests accepted in later cycles use the new base.
- R11: `acc_ready` equals NOT `d_valid` OR `d_ready`. While `d_valid` is high and `d_ready` is low, the dispatch fields hold. A drained register with no new request returns `d_valid` low.
- R12: ROUTE raises exactly one `d_target` bit. Every other status raises none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_en | input | 1 | I/O decode enable |
| bm_en | input | 1 | Bus-master write enable |
| dev_present | input | 4 | Drive present, index {channel, select} |
| base_we | input | 1 | Window base write strobe |
| base_idx | input | 3 | Window number for the base write |
| base_wdata | input | AW | New base value |
| acc_valid | input | 1 | Request valid |
| acc_ready | output | 1 | Request accepted this cycle |
| acc_addr | input | AW | Request address |
| acc_size | input | 3 | Request size in bytes |
| acc_write | input | 1 | 1 = write |
| acc_wdata | input | DW | Write data |
| d_valid | output | 1 | Dispatch record valid |
| d_ready | input | 1 | Dispatch consumer ready |
| d_status | output | 2 | 0 ROUTE, 1 SKIP, 2 EMPTY, 3 ERR |
| d_target | output | 6 | One-hot target strobe |
| d_offset | output | AW | Offset within the target |
| d_dev | output | 1 | Selected drive for command/control |
| d_write | output | 1 | Direction copy |
| d_size | output | 3 | Size copy |
| d_wdata | output | DW | Write data copy |

## Verification
The hardest case to reach is a select update that changes the presence outcome of the same access. A primary command write at raw offset 12 or 13 shifts down to 6 and flips the select. Only that access then sees whether the newly chosen drive is present. The stimulus sets up directed cases where only one drive exists, and mixes random presence masks with addresses biased onto window edges. Overlapping windows are produced by reprogramming a base so that it lands inside another window.

// File: rtl/stor_dec_pkg.sv
package stor_dec_pkg;
  typedef enum logic [1:0] {
    ST_ROUTE = 2'd0,
    ST_SKIP  = 2'd1,
    ST_EMPTY = 2'd2,
    ST_ERR   = 2'd3
  } disp_st_e;

  localparam int N_WIN  = 5;
  localparam int N_TGT  = 6;
  localparam int N_CH   = 2;
  localparam int WIN_BM = 4;
endpackage

// File: rtl/stor_dec_window.sv
module stor_dec_window #(
  parameter int          AW       = 16,
  parameter int unsigned SIZE     = 8,
  parameter int unsigned RST_BASE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic [AW-1:0] base_wdata,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [AW-1:0] offset
);
  localparam logic [AW:0] SIZE_W = (AW+1)'(SIZE);

  logic [AW-1:0] base_q;
  logic [AW:0]   lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        base_q <= AW'(RST_BASE);
    else if (base_we && base_wdata != '0) base_q <= base_wdata;
  end

  assign lim    = {1'b0, base_q} + SIZE_W;
  assign hit    = ({1'b0, addr} >= {1'b0, base_q}) && ({1'b0, addr} < lim);
  assign offset = addr - base_q;

  p_zero_base_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (base_we && base_wdata == '0) |=> $stable(base_q));
endmodule

// File: rtl/stor_dec_devsel.sv
module stor_dec_devsel #(
  parameter int N_CH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] upd,
  input  logic [N_CH-1:0] val,
  output logic [N_CH-1:0] sel
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel[c] <= 1'b0;
      else if (upd[c]) sel[c] <= val[c];
    end
  end

  p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd == '0) |=> $stable(sel));
endmodule

// File: rtl/stor_addr_decoder.sv
module stor_addr_decoder
  import stor_dec_pkg::*;
#(
  parameter int          AW            = 16,
  parameter int          DW            = 32,
  parameter int          IO_SHIFT      = 1,
  parameter int unsigned CTRL_ADJ      = 2,
  parameter int unsigned PCMD_BYTES    = 16,
  parameter int unsigned SCMD_BYTES    = 8,
  parameter int unsigned CTL_BYTES     = 4,
  parameter int unsigned BM_BYTES      = 16,
  parameter int unsigned BM_CHAN_BYTES = 8,
  parameter int unsigned SEL_OFFSET    = 6,
  parameter int          SEL_BIT       = 4,
  parameter int unsigned PCMD_BASE     = 'h01F0,
  parameter int unsigned PCTL_BASE     = 'h03F4,
  parameter int unsigned SCMD_BASE     = 'h0170,
  parameter int unsigned SCTL_BASE     = 'h0374,
  parameter int unsigned BM_BASE       = 'hC000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            io_en,
  input  logic            bm_en,
  input  logic [3:0]      dev_present,
  input  logic            base_we,
  input  logic [2:0]      base_idx,
  input  logic [AW-1:0]   base_wdata,
  input  logic            acc_valid,
  output logic            acc_ready,
  input  logic [AW-1:0]   acc_addr,
  input  logic [2:0]      acc_size,
  input  logic            acc_write,
  input  logic [DW-1:0]   acc_wdata,
  output logic            d_valid,
  input  logic            d_ready,
  output logic [1:0]      d_status,
  output logic [5:0]      d_target,
  output logic [AW-1:0]   d_offset,
  output logic            d_dev,
  output logic            d_write,
  output logic [2:0]      d_size,
  output logic [DW-1:0]   d_wdata
);
  function automatic int unsigned win_size(int i);
    case (i)
      0:       return PCMD_BYTES;
      2:       return SCMD_BYTES;
      4:       return BM_BYTES;
      default: return CTL_BYTES;
    endcase
  endfunction

  function automatic int unsigned win_base(int i);
    case (i)
      0:       return PCMD_BASE;
      1:       return PCTL_BASE;
      2:       return SCMD_BASE;
      3:       return SCTL_BASE;
      default: return BM_BASE;
    endcase
  endfunction

  logic [N_WIN-1:0] hit;
  logic [AW-1:0]    off_w [N_WIN];

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    stor_dec_window #(
      .AW      (AW),
      .SIZE    (win_size(w)),
      .RST_BASE(win_base(w))
    ) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .base_we   (base_we && base_idx == 3'(w)),
      .base_wdata(base_wdata),
      .addr      (acc_addr),
      .hit       (hit[w]),
      .offset    (off_w[w])
    );
  end

  logic [N_CH-1:0] sel_q, sel_upd, sel_val;

  stor_dec_devsel #(.N_CH(N_CH)) u_sel (
    .clk  (clk),
    .rst_n(rst_n),
    .upd  (sel_upd),
    .val  (sel_val),
    .sel  (sel_q)
  );

  logic acc_fire;
  assign acc_ready = !d_valid || d_ready;
  assign acc_fire  = acc_valid && acc_ready;

  // First-hit window, lowest index wins
  logic       win_hit;
  logic [2:0] win_idx;
  always_comb begin
    win_hit = 1'b0;
    win_idx = '0;
    for (int i = N_WIN-1; i >= 0; i--) begin
      if (hit[i]) begin
        win_hit = 1'b1;
        win_idx = 3'(i);
      end
    end
  end

  logic             size_ok;
  logic [AW-1:0]    raw_off, adj_off;
  logic             ch, sel_now;
  disp_st_e         nx_st;
  logic [N_TGT-1:0] nx_tgt;
  logic [AW-1:0]    nx_off;
  logic             nx_dev;

  assign size_ok = (acc_size == 3'd1) || (acc_size == 3'd2) || (acc_size == 3'd4);
  assign raw_off = off_w[win_idx];
  assign ch      = win_idx[1];

  always_comb begin
    case (win_idx)
      3'd0:    adj_off = raw_off >> IO_SHIFT;
      3'd1:    adj_off = raw_off + AW'(CTRL_ADJ);
      default: adj_off = raw_off;
    endcase
  end

  always_comb begin
    nx_st   = ST_ERR;
    nx_tgt  = '0;
    nx_off  = '0;
    nx_dev  = 1'b0;
    sel_upd = '0;
    sel_val = sel_q;
    sel_now = sel_q[ch];
    if (!size_ok) begin
      nx_st = ST_ERR;
    end else if (!io_en) begin
      nx_st = ST_SKIP;
    end else if (!win_hit) begin
      nx_st = ST_ERR;
    end else if (win_idx == 3'(WIN_BM)) begin
      if (acc_write && !bm_en) begin
        nx_st = ST_SKIP;
      end else begin
        nx_st = ST_ROUTE;
        if (raw_off < AW'(BM_CHAN_BYTES)) begin
          nx_tgt[4] = 1'b1;
          nx_off    = raw_off;
        end else begin
          nx_tgt[5] = 1'b1;
          nx_off    = raw_off - AW'(BM_CHAN_BYTES);
        end
      end
    end else begin
      nx_off = adj_off;
      if (!win_idx[0] && acc_write && adj_off == AW'(SEL_OFFSET)) begin
        sel_now     = acc_wdata[SEL_BIT];
        sel_upd[ch] = acc_fire;
        sel_val[ch] = acc_wdata[SEL_BIT];
      end
      nx_dev = sel_now;
      if (dev_present[{ch, sel_now}]) begin
        nx_st           = ST_ROUTE;
        nx_tgt[win_idx] = 1'b1;
      end else if (acc_size == 3'd1) begin
        nx_st = ST_EMPTY;
      end else begin
        nx_st = ST_ERR;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_valid  <= 1'b0;
      d_status <= '0;
      d_target <= '0;
      d_offset <= '0;
      d_dev    <= 1'b0;
      d_write  <= 1'b0;
      d_size   <= '0;
      d_wdata  <= '0;
    end else if (acc_fire) begin
      d_valid  <= 1'b1;
      d_status <= nx_st;
      d_target <= nx_tgt;
      d_offset <= nx_off;
      d_dev    <= nx_dev;
      d_write  <= acc_write;
      d_size   <= acc_size;
      d_wdata  <= acc_wdata;
    end else if (d_ready) begin
      d_valid  <= 1'b0;
    end
  end

  p_route_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && d_status == ST_ROUTE) |-> $onehot(d_target));

  p_nonroute_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && d_status != ST_ROUTE) |-> (d_target == '0));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && !d_ready) |=> (d_valid && $stable(d_target) && $stable(d_offset)
                               && $stable(d_status) && $stable(d_dev)));

  p_bad_size_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && !(d_size == 3'd1 || d_size == 3'd2 || d_size == 3'd4))
      |-> (d_status == ST_ERR));

  p_io_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !io_en && size_ok) |=> (d_status == ST_SKIP && d_target == '0));
endmodule

// File: tb/stor_addr_decoder_tb.sv
`timescale 1ns/1ps
module stor_addr_decoder_tb;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          io_en = 1'b1, bm_en = 1'b1;
  logic [3:0]    dev_present = 4'hF;
  logic          base_we = 1'b0;
  logic [2:0]    base_idx = '0;
  logic [AW-1:0] base_wdata = '0;
  logic          acc_valid = 1'b0;
  logic          acc_ready;
  logic [AW-1:0] acc_addr = '0;
  logic [2:0]    acc_size = 3'd1;
  logic          acc_write = 1'b0;
  logic [DW-1:0] acc_wdata = '0;
  logic          d_valid, d_ready = 1'b0;
  logic [1:0]    d_status;
  logic [5:0]    d_target;
  logic [AW-1:0] d_offset;
  logic          d_dev, d_write;
  logic [2:0]    d_size;
  logic [DW-1:0] d_wdata;

  always #4 clk = ~clk;

  stor_addr_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .io_en(io_en), .bm_en(bm_en),
    .dev_present(dev_present), .base_we(base_we), .base_idx(base_idx),
    .base_wdata(base_wdata), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_write(acc_write),
    .acc_wdata(acc_wdata), .d_valid(d_valid), .d_ready(d_ready),
    .d_status(d_status), .d_target(d_target), .d_offset(d_offset),
    .d_dev(d_dev), .d_write(d_write), .d_size(d_size), .d_wdata(d_wdata)
  );

  int checks = 0;
  int failures = 0;

  // Bench model state
  int   m_base [5] = '{'h01F0, 'h03F4, 'h0170, 'h0374, 'hC000};
  int   m_size [5] = '{16, 4, 8, 4, 16};
  logic m_sel  [2] = '{1'b0, 1'b0};

  logic [1:0]    exp_st;
  logic [5:0]    exp_tgt;
  logic [AW-1:0] exp_off;
  logic          exp_dev;
  logic          exp_cc;
  string         exp_req;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [AW-1:0] a, input logic [2:0] sz,
                       input logic w, input logic [DW-1:0] wd);
    int win;
    int off;
    int ch;
    exp_tgt = '0; exp_off = '0; exp_dev = 1'b0; exp_cc = 1'b0; exp_req = "R3";
    if (!(sz == 1 || sz == 2 || sz == 4)) begin exp_st = 2'd3; exp_req = "R1"; return; end
    if (!io_en) begin exp_st = 2'd1; exp_req = "R2"; return; end
    win = -1;
    for (int i = 0; i < 5; i++)
      if (win < 0 && int'(a) >= m_base[i] && int'(a) < m_base[i] + m_size[i]) win = i;
    if (win < 0) begin exp_st = 2'd3; exp_req = "R9"; return; end
    off = int'(a) - m_base[win];
    if (win == 4) begin
      if (w && !bm_en) begin exp_st = 2'd1; exp_req = "R6"; return; end
      exp_st = 2'd0; exp_req = "R5";
      if (off < 8) begin exp_tgt = 6'b01_0000; exp_off = AW'(off); end
      else         begin exp_tgt = 6'b10_0000; exp_off = AW'(off - 8); end
      return;
    end
    ch = win / 2;
    exp_cc = 1'b1;
    if (win == 0) begin off = off >> 1; exp_req = "R4"; end
    if (win == 1) begin off = off + 2;  exp_req = "R4"; end
    exp_off = AW'(off);
    if (win % 2 == 0 && w && off == 6) begin m_sel[ch] = wd[4]; exp_req = "R7"; end
    exp_dev = m_sel[ch];
    if (!dev_present[ch*2 + int'(m_sel[ch])]) begin
      exp_st = (sz == 1) ? 2'd2 : 2'd3; exp_req = "R8";
    end else begin
      exp_st = 2'd0; exp_tgt = 6'(1 << win);
    end
  endtask

  task automatic compare();
    chk(d_valid == 1'b1, "R11", "d_valid", d_valid, 1);
    chk(d_status == exp_st, exp_req, "status", d_status, exp_st);
    chk(d_target == exp_tgt, "R12", "target", d_target, exp_tgt);
    if (exp_st == 2'd0) chk(d_offset == exp_off, exp_req, "offset", d_offset, exp_off);
    if (exp_cc && (exp_st == 2'd0 || exp_st == 2'd2))
      chk(d_dev == exp_dev, "R7", "dev", d_dev, exp_dev);
  endtask

  task automatic send(input logic [AW-1:0] a, input logic [2:0] sz,
                      input logic w, input logic [DW-1:0] wd, input int stall);
    @(negedge clk);
    acc_addr = a; acc_size = sz; acc_write = w; acc_wdata = wd;
    acc_valid = 1'b1; d_ready = 1'b0;
    model(a, sz, w, wd);
    @(negedge clk);
    acc_valid = 1'b0;
    compare();
    for (int s = 0; s < stall; s++) begin
      chk(acc_ready == 1'b0, "R11", "acc_ready stalled", acc_ready, 0);
      @(negedge clk);
      compare();
    end
    d_ready = 1'b1;
    @(negedge clk);
    chk(d_valid == 1'b0, "R11", "drained", d_valid, 0);
    d_ready = 1'b0;
  endtask

  task automatic set_base(input int idx, input int val);
    @(negedge clk);
    base_we = 1'b1; base_idx = 3'(idx); base_wdata = AW'(val);
    if (idx < 5 && val != 0) m_base[idx] = val;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(d_valid == 1'b0, "R11", "reset d_valid", d_valid, 0);
    chk(acc_ready == 1'b1, "R11", "reset acc_ready", acc_ready, 1);

    // R7: reset selects master; only primary master present
    dev_present = 4'b0001;
    send(16'h01F2, 3'd1, 1'b0, 0, 0);
    // R1: illegal sizes
    send(16'h01F0, 3'd3, 1'b0, 0, 1);
    send(16'hC000, 3'd0, 1'b1, 0, 0);
    // R2: gated select write must not change select
    io_en = 1'b0;
    send(16'h01FC, 3'd1, 1'b1, 32'h10, 2);
    io_en = 1'b1;
    send(16'h01F0, 3'd2, 1'b0, 0, 0);
    // R4: shift and adjust
    send(16'h01F9, 3'd1, 1'b0, 0, 0);
    send(16'h03F5, 3'd1, 1'b0, 0, 0);
    // R7 + R8: flip primary to absent slave in same access
    send(16'h01FD, 3'd1, 1'b1, 32'h10, 0);
    send(16'h01F2, 3'd2, 1'b0, 0, 0);
    send(16'h03F6, 3'd1, 1'b0, 0, 1);
    send(16'h01FC, 3'd1, 1'b1, 32'h00, 0);
    // R7 secondary
    dev_present = 4'b1111;
    send(16'h0176, 3'd1, 1'b1, 32'hFF, 0);
    send(16'h0171, 3'd1, 1'b0, 0, 0);
    // R5 split
    send(16'hC003, 3'd1, 1'b0, 0, 0);
    send(16'hC00B, 3'd4, 1'b0, 0, 1);
    // R6
    bm_en = 1'b0;
    send(16'hC002, 3'd1, 1'b1, 32'h5, 0);
    send(16'hC00A, 3'd1, 1'b0, 0, 0);
    bm_en = 1'b1;
    // R9
    send(16'h0005, 3'd1, 1'b0, 0, 0);
    send(16'hC010, 3'd1, 1'b0, 0, 0);
    // R10: zero ignored, nonzero moves; R3 overlap priority
    set_base(4, 0);
    send(16'hC004, 3'd1, 1'b0, 0, 0);
    set_base(4, 'hD000);
    send(16'hD00C, 3'd2, 1'b0, 0, 0);
    send(16'hC004, 3'd1, 1'b0, 0, 0);
    set_base(2, 'h01F8);
    send(16'h01FA, 3'd1, 1'b0, 0, 0);
    send(16'h01FF, 3'd1, 1'b0, 0, 0);
    set_base(2, 'h0170);
    set_base(7, 'h1234);

    // Constrained random
    for (int n = 0; n < 400; n++) begin
      int w;
      int a;
      logic [2:0] sz;
      logic [2:0] sizes [8] = '{3'd1, 3'd2, 3'd4, 3'd1, 3'd2, 3'd4, 3'd3, 3'd0};
      if (n % 25 == 0) dev_present = 4'($urandom);
      io_en = ($urandom % 10) != 0;
      bm_en = ($urandom % 5) != 0;
      w = $urandom % 7;
      if (w < 5) a = m_base[w] + int'($urandom % (m_size[w] + 2)) - 1;
      else if (w == 5) a = int'($urandom % 65536);
      else a = m_base[$urandom % 5] - 1;
      sz = sizes[$urandom % 8];
      send(AW'(a), sz, 1'($urandom), (($urandom % 2) != 0) ? 32'h10 : 32'h0, int'($urandom % 3));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule